// File: doc/BRIEF.md
# Selectable Power-of-Two Clock-Enable Generator

This block produces a one-cycle enable strobe in the system clock domain, so that slower logic can run on the main clock at a reduced rate without a divided clock being built from logic. A free-running counter advances on every clock edge while the block runs. A priority decode of a select vector picks one counter bit as the tap. A registered edge detector on that tap raises the strobe once per tap period.

A two-bit run code gates the whole function. Only the code `10` lets the counter advance. Any other code holds the counter and both outputs at zero. Reset is synchronous. A registered copy of the tapped bit is also brought out, for observation only.

Top module: `clk_en_gen`

## Requirements
- R1: While running, after the k-th clock edge since the count restarted, `tap_level` equals bit n of the value k-1, where n is the selected tap.
- R2: The tap n is the highest set bit of `div_sel` among bits 7..1. When none of those bits is set, the tap is 0. Lower set bits do not change the tap.
- R3: With tap n held, `tick` is high after edge 2^n+1 and then once every 2^(n+1) edges. It is high for exactly one cycle each time, and it is never high while `tap_level` is low.
- R4: When `mode` is not binary `10`, the next clock edge forces `tick` and `tap_level` to 0, and they stay at 0 for as long as the code is held.
- R5: A high `rst` at a clock edge clears the counter and both outputs. Once `rst` is released, counting restarts from zero, and this takes priority over any run code or tap change in that same cycle.
- R6: At an edge where the selected tap differs from the one used at the previous edge, no strobe is issued. `tap_level` takes the new tap's bit, and later strobes follow the new tap's counter bit.
- R7: When `mode` returns to `10` after any other code, counting restarts from zero, as it does after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | 8 | Divide select; the highest set bit picks the tap |
| mode | input | 2 | Run code; only `10` lets the block count |
| tick | output | 1 | One-cycle enable strobe |
| tap_level | output | 1 | Registered level of the tapped counter bit |

## Verification
The edge detector and the tap decode can act in the same cycle. The bench runs tap 0 for five edges and then switches to tap 2 at the exact edge where the new tap's bit reads 1 and the stored history reads 0. A strobe must not appear there, `tap_level` must read 1, and the next strobe must arrive only at the new tap's next rising edge. In a second test, a reset and a tap change are applied in the same cycle, and the run after release must match a clean start on the new tap.

// File: rtl/clk_en_gen.sv
module clk_en_gen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] div_sel,
  input  logic [1:0]       mode,
  output logic             tick,
  output logic             tap_level
);
  localparam int          TAP_W    = (CNT_W > 1) ? $clog2(CNT_W) : 1;
  localparam logic [1:0]  RUN_CODE = 2'b10;

  logic [CNT_W-1:0] cnt;
  logic [TAP_W-1:0] tap, tap_q;
  logic             run, tap_bit, moved;

  always_comb begin
    tap = '0;
    for (int i = 1; i < CNT_W; i++)
      if (div_sel[i]) tap = TAP_W'(i);
  end

  assign run     = (mode == RUN_CODE);
  assign tap_bit = cnt[tap];
  assign moved   = (tap != tap_q);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt       <= '0;
      tick      <= 1'b0;
      tap_level <= 1'b0;
      tap_q     <= tap;
    end else begin
      cnt       <= cnt + 1'b1;
      tap_q     <= tap;
      tap_level <= tap_bit;
      tick      <= tap_bit & ~tap_level & ~moved;
    end
  end
endmodule

module clk_en_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] mode,
  input logic       tick,
  input logic       tap_level
);
  // R3
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R3
  tick_level_chk: assert property (@(posedge clk) disable iff (rst)
    tick |-> tap_level);

  // R4
  mode_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != 2'b10) |=> (!tick && !tap_level));

  // R5
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!tick && !tap_level));
endmodule

bind clk_en_gen clk_en_gen_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .tick(tick), .tap_level(tap_level)
);

// File: tb/clk_en_gen_bench.sv
module clk_en_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] div_sel = 8'h00;
  logic [1:0] mode = 2'b00;
  logic       tick, tap_level;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_en_gen u_clk_en_gen (
    .clk(clk), .rst(rst), .div_sel(div_sel), .mode(mode),
    .tick(tick), .tap_level(tap_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    chk(tick == 0, "R5 tick in reset", tick, 0);
    chk(tap_level == 0, "R5 level in reset", tap_level, 0);
    rst = 1'b0;
  endtask

  // Expected values after edge e, counted from a clean restart, with tap n
  task automatic follow(input int n, input int e0, input int edges, input string req);
    int half = 1 << n;
    int per  = 1 << (n + 1);
    for (int e = e0; e < e0 + edges; e++) begin
      bit et, el;
      step();
      et = (e >= half + 1) && (((e - 1 - half) % per) == 0);
      el = ((e - 1) >> n) & 1;
      chk(tick == et, {req, " tick"}, tick, et);
      chk(tap_level == el, {"R1 ", req, " level"}, tap_level, el);
    end
  endtask

  task automatic test_taps();
    for (int n = 0; n < 8; n++) begin
      mode = 2'b10;
      // R2: lower set bits must not change the tap
      div_sel = (n == 0) ? 8'h00 : (8'(1 << n) | (8'((1 << n) - 1) & 8'hA5));
      do_reset();
      follow(n, 1, 3 * (2 << n) + (1 << n), "R2 R3 tap");
    end
    mode = 2'b10;
    div_sel = 8'h01;
    do_reset();
    follow(0, 1, 12, "R2 bit0 only");
  endtask

  task automatic test_modes();
    logic [1:0] codes [3] = '{2'b00, 2'b01, 2'b11};
    for (int i = 0; i < 3; i++) begin
      mode = codes[i];
      div_sel = 8'h00;
      do_reset();
      for (int c = 0; c < 40; c++) begin
        step();
        chk(tick == 0, "R4 tick gated", tick, 0);
        chk(tap_level == 0, "R4 level gated", tap_level, 0);
      end
    end
    mode = 2'b10;
    div_sel = 8'h00;
    do_reset();
    follow(0, 1, 6, "R3 pre-gate");
    mode = 2'b01;
    for (int c = 0; c < 20; c++) begin
      step();
      chk(tick == 0, "R4 tick mid-run gate", tick, 0);
      chk(tap_level == 0, "R4 level mid-run gate", tap_level, 0);
    end
    mode = 2'b10;
    follow(0, 1, 12, "R7 re-enable");
  endtask

  task automatic test_reset_mid();
    mode = 2'b10;
    div_sel = 8'h04;
    do_reset();
    follow(2, 1, 10, "R3 pre-reset");
    rst = 1'b1;
    div_sel = 8'h08;
    step();
    chk(tick == 0, "R5 tick mid reset", tick, 0);
    chk(tap_level == 0, "R5 level mid reset", tap_level, 0);
    rst = 1'b0;
    follow(3, 1, 40, "R5 restart");
  endtask

  task automatic test_sel_change();
    mode = 2'b10;
    div_sel = 8'h00;
    do_reset();
    follow(0, 1, 5, "R3 tap0");
    div_sel = 8'h04;
    step();
    chk(tick == 0, "R6 no strobe on tap change", tick, 0);
    chk(tap_level == 1, "R6 level on tap change", tap_level, 1);
    follow(2, 7, 10, "R6 after change");
  endtask

  initial begin
    step();
    test_taps();
    test_modes();
    test_reset_mid();
    test_sel_change();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule